// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Scheduler

This block decides when an asynchronous DRAM needs a refresh slot and asks the access controller for it. It does not drive the memory pins. After reset it waits out a fixed power-up pause. It then asks for a burst of wake-up strobe cycles. Once the last of those is granted, it raises `init_done`, and ordinary traffic may start. From then on a clock divider creates one owed refresh per interval. The interval is derived from the clock frequency so that every row count is covered within the retention window. The default is 1024 refreshes per 16 ms, which at 50 MHz is one every 781 cycles.

Owed refreshes pile up in a saturating debt counter, so the controller can postpone a few of them while it finishes a burst of traffic. `overdue` warns once the debt passes a threshold. If a new refresh falls due while the debt is already at its ceiling and none is served in that cycle, the retention deadline counts as missed. The scheduler then drops `init_done`, clears the debt and runs the wake-up burst again. The power-up pause is not repeated.

`ref_req`/`ref_ack` follow valid/ready rules. `ref_req` is the valid and `ref_ack` is the ready. A refresh is granted on every rising clock edge where both are high. Once raised, `ref_req` does not fall until a grant has occurred. The controller may hold `ref_ack` high for as long as it likes, and `ref_ack` means nothing while `ref_req` is low.

Top module: `rfs_sched`

## Requirements
- R1: After reset `ref_req`, `init_done` and `overdue` are low, and `ref_req` first rises on exactly the PAUSE_CYC-th rising edge after reset release (PAUSE_CYC = CLK_HZ × PAUSE_US / 10^6, which is 10000 by default).
- R2: During the wake-up phase `ref_req` is high continuously, and `init_done` goes high in the cycle after the WAKE_CYCLES-th grant (default 8), not earlier.
- R3: A high `ref_ack` while `ref_req` is low is ignored. It neither shortens the pause, nor counts as a wake-up grant, nor retires a future refresh.
- R4: From the edge that enters normal operation, a refresh becomes owed every INTERVAL_CYC edges (CLK_HZ × RETENTION_US / (10^6 × REFRESH_ROWS), which is 781 by default).
- R5: In normal operation `ref_req` is high exactly while the debt is non-zero, and each grant retires one owed refresh.
- R6: Once `ref_req` is high it stays high until a grant occurs.
- R7: `overdue` is high exactly while the debt exceeds DEBT_WARN (default 4).
- R8: If a refresh falls due while the debt equals DEBT_MAX (default 8) and no grant occurs in that cycle, then `init_done` falls in the next cycle, `overdue` clears, `ref_req` stays high, and a new burst of WAKE_CYCLES grants is needed before `init_done` returns.
- R9: When a refresh falls due in the same cycle as a grant, the debt is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_req | output | 1 | Refresh slot wanted (valid) |
| ref_ack | input | 1 | Controller takes the slot (ready) |
| init_done | output | 1 | Power-up and wake-up complete; normal access allowed |
| overdue | output | 1 | Refresh debt above the warning threshold |

## Verification
All three outputs are decoded from registered state. Each one therefore changes in the cycle after the edge that causes it: the PAUSE_CYC-th edge for the first request, the edge of the last wake-up grant for `init_done`, and the edge of a due tick or a grant for the debt. The bench keeps a behavioural model that it steps on the same rising edge as the design. It compares all three outputs on every falling edge, so every check samples one half-cycle after the update it targets. The directed checks count falling edges from a known edge and expect the exact counts: PAUSE_CYC, INTERVAL_CYC−1, 4×INTERVAL_CYC, and the nine-tick distance to a missed deadline.

// File: rtl/rfs_pkg.sv
package rfs_pkg;

  typedef enum logic [1:0] {
    PH_PAUSE = 2'd0,
    PH_WAKE  = 2'd1,
    PH_RUN   = 2'd2
  } phase_e;

  // bits needed to hold the values 0 .. n-1
  function automatic int unsigned cnt_width(input longint unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/rfs_divider.sv
// Free-running period counter: held at zero while disabled,
// pulses tick on the last cycle of every PERIOD-cycle window.
module rfs_divider #(
  parameter longint unsigned PERIOD = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  localparam int unsigned CW = rfs_pkg::cnt_width(PERIOD);
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  logic [CW-1:0] cnt_q;

  assign tick = en && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt_q <= '0;
    else if (!en)   cnt_q <= '0;
    else if (tick)  cnt_q <= '0;
    else            cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/rfs_debt.sv
// Saturating count of refreshes owed but not yet granted.
module rfs_debt #(
  parameter int unsigned MAX  = 8,
  parameter int unsigned WARN = 4,
  localparam int unsigned DW  = rfs_pkg::cnt_width(longint'(MAX) + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc,
  input  logic          dec,
  input  logic          flush,
  output logic [DW-1:0] level,
  output logic          empty,
  output logic          full,
  output logic          over
);
  localparam logic [DW-1:0] TOP  = DW'(MAX);
  localparam logic [DW-1:0] WLIM = DW'(WARN);

  assign empty = (level == '0);
  assign full  = (level == TOP);
  assign over  = (level > WLIM);

  always_ff @(posedge clk) begin
    if (!rst_n || flush)               level <= '0;
    else if (inc && !dec && !full)     level <= level + 1'b1;
    else if (dec && !inc && !empty)    level <= level - 1'b1;
  end
endmodule

// File: rtl/rfs_seq.sv
// Phase sequencer: pause, wake-up burst, normal run, back to wake on a miss.
module rfs_seq #(
  parameter int unsigned WAKE_CYCLES = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pause_done,
  input  logic            grant,
  input  logic            miss,
  output rfs_pkg::phase_e phase
);
  import rfs_pkg::*;
  localparam int unsigned WW = cnt_width(WAKE_CYCLES);
  localparam logic [WW-1:0] WLAST = WW'(WAKE_CYCLES - 1);

  logic [WW-1:0] wake_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase  <= PH_PAUSE;
      wake_q <= '0;
    end else begin
      case (phase)
        PH_PAUSE: if (pause_done) begin
          phase  <= PH_WAKE;
          wake_q <= '0;
        end
        PH_WAKE: if (grant) begin
          if (wake_q == WLAST) begin
            phase  <= PH_RUN;
            wake_q <= '0;
          end else begin
            wake_q <= wake_q + 1'b1;
          end
        end
        PH_RUN: if (miss) begin
          phase  <= PH_WAKE;
          wake_q <= '0;
        end
        default: phase <= PH_PAUSE;
      endcase
    end
  end
endmodule

// File: rtl/rfs_sched.sv
module rfs_sched #(
  parameter int unsigned CLK_HZ       = 50_000_000,
  parameter int unsigned RETENTION_US = 16_000,
  parameter int unsigned REFRESH_ROWS = 1024,
  parameter int unsigned PAUSE_US     = 200,
  parameter int unsigned WAKE_CYCLES  = 8,
  parameter int unsigned DEBT_MAX     = 8,
  parameter int unsigned DEBT_WARN    = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic ref_req,
  input  logic ref_ack,
  output logic init_done,
  output logic overdue
);
  import rfs_pkg::*;

  localparam longint unsigned PAUSE_CYC =
    (longint'(CLK_HZ) * longint'(PAUSE_US)) / 64'd1_000_000;
  localparam longint unsigned INTERVAL_CYC =
    (longint'(CLK_HZ) * longint'(RETENTION_US)) /
    (64'd1_000_000 * longint'(REFRESH_ROWS));
  localparam int unsigned DEBT_W = cnt_width(longint'(DEBT_MAX) + 1);

  phase_e            phase;
  logic              pause_done, due_tick, grant, serve, miss;
  logic [DEBT_W-1:0] debt_level;
  logic              debt_empty, debt_full, debt_over;

  rfs_divider #(.PERIOD((PAUSE_CYC > 0) ? PAUSE_CYC : 1)) u_pause (
    .clk(clk), .rst_n(rst_n), .en(phase == PH_PAUSE), .tick(pause_done));

  rfs_divider #(.PERIOD((INTERVAL_CYC > 0) ? INTERVAL_CYC : 1)) u_interval (
    .clk(clk), .rst_n(rst_n), .en(phase == PH_RUN), .tick(due_tick));

  assign grant = ref_req && ref_ack;
  assign serve = grant && (phase == PH_RUN);
  assign miss  = due_tick && debt_full && !serve;

  rfs_debt #(.MAX(DEBT_MAX), .WARN(DEBT_WARN)) u_debt (
    .clk(clk), .rst_n(rst_n), .inc(due_tick), .dec(serve), .flush(miss),
    .level(debt_level), .empty(debt_empty), .full(debt_full), .over(debt_over));

  rfs_seq #(.WAKE_CYCLES(WAKE_CYCLES)) u_seq (
    .clk(clk), .rst_n(rst_n), .pause_done(pause_done), .grant(grant),
    .miss(miss), .phase(phase));

  assign ref_req   = (phase == PH_WAKE) || ((phase == PH_RUN) && !debt_empty);
  assign init_done = (phase == PH_RUN);
  assign overdue   = debt_over;
endmodule

// File: rtl/rfs_sched_chk.sv
module rfs_sched_chk #(
  parameter int unsigned DEBT_MAX = 8,
  parameter int unsigned DW       = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ref_req,
  input logic            ref_ack,
  input logic            init_done,
  input logic            overdue,
  input rfs_pkg::phase_e phase,
  input logic [DW-1:0]   debt
);
  // R6
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_req && !ref_ack |=> ref_req);

  // R2
  init_after_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(init_done) |-> $past(ref_req && ref_ack));

  // R7
  overdue_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overdue |-> init_done);

  // R8
  drop_on_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(init_done) |-> ($past(debt) == DW'(DEBT_MAX)) && ref_req && !overdue);

  // R5
  debt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_done && $past(init_done) |->
      (int'(debt) <= int'($past(debt)) + 1) && (int'(debt) + 1 >= int'($past(debt))));

  // R1
  pause_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase == rfs_pkg::PH_PAUSE |-> !init_done && !overdue);
endmodule

bind rfs_sched rfs_sched_chk #(.DEBT_MAX(DEBT_MAX), .DW(DEBT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ref_req(ref_req), .ref_ack(ref_ack),
  .init_done(init_done), .overdue(overdue), .phase(phase), .debt(debt_level));

// File: tb/rfs_sched_tb.sv
module rfs_sched_tb;
  localparam int P    = 10000;
  localparam int T    = 781;
  localparam int WK   = 8;
  localparam int DMAX = 8;
  localparam int WARN = 4;

  logic clk = 1'b0, rst_n = 1'b0, ref_ack = 1'b0;
  logic ref_req, init_done, overdue;

  always #10 clk = ~clk;

  rfs_sched u_dut (.clk(clk), .rst_n(rst_n), .ref_req(ref_req), .ref_ack(ref_ack),
                   .init_done(init_done), .overdue(overdue));

  int n_tests = 0, n_fail = 0, cyc = 0;
  bit cmp_on = 0, finished = 0;

  // behavioural reference: phase 0 pause, 1 wake, 2 run
  int ms = 0, mp = 0, mw = 0, mi = 0, md = 0;

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      ms = 0; mp = 0; mw = 0; mi = 0; md = 0;
    end else begin
      case (ms)
        0: if (mp == P - 1) begin ms = 1; mw = 0; end else mp++;
        1: if (ref_ack) begin
             if (mw == WK - 1) begin ms = 2; mi = 0; md = 0; end else mw++;
           end
        default: begin
          automatic bit tk = (mi == T - 1);
          automatic bit sv = ref_ack && (md > 0);
          mi = tk ? 0 : mi + 1;
          if (tk && md == DMAX && !sv) begin ms = 1; mw = 0; md = 0; end
          else md = md + (tk ? 1 : 0) - (sv ? 1 : 0);
        end
      endcase
    end
  end

  task automatic chk(input string r, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", r, cyc, act, exp);
    end
  endtask

  always @(negedge clk) if (cmp_on) begin
    chk(ms == 0 ? "R1 req" : ms == 1 ? "R2 req" : "R5 req", int'(ref_req),
        int'(ms == 1 || (ms == 2 && md > 0)));
    chk(ms == 1 ? "R8 init" : "R2 init", int'(init_done), int'(ms == 2));
    chk("R7 overdue", int'(overdue), int'(ms == 2 && md > WARN));
  end

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  always @(posedge clk) if (cyc > 150000 && !finished) begin
    finished = 1;
    n_tests++; n_fail++;
    $display("FAIL watchdog R1..: actual %0d cycles expected fewer", cyc);
    summary();
  end

  task automatic drain(output int n);
    n = 0;
    ref_ack = 1'b1;
    while (ref_req && n < 40) begin @(negedge clk); n++; end
    ref_ack = 1'b0;
  endtask

  initial begin
    int rise, w, n, exp;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1", int'(ref_req), 0);
    chk("R1", int'(init_done), 0);
    chk("R1", int'(overdue), 0);
    rst_n = 1'b1;
    cmp_on = 1;

    // R1 pause length, R3 acks during pause ignored
    rise = 0;
    for (int i = 1; i <= P + 2; i++) begin
      ref_ack = (i % 3 == 0) && (i < P - 10);
      @(negedge clk);
      if (ref_req && rise == 0) rise = i;
    end
    ref_ack = 1'b0;
    chk("R1", rise, P);
    chk("R3", int'(ref_req), 1);

    // R6 request held without grant
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk("R6", int'(ref_req), 1);
    end

    // R2 wake burst with gaps
    n = 0;
    while (n < WK) begin
      ref_ack = 1'b1; @(negedge clk); n++;
      chk("R2", int'(init_done), int'(n == WK));
      ref_ack = 1'b0; @(negedge clk);
      chk("R2", int'(init_done), int'(n == WK));
    end

    // R4 first and second interval
    w = 0;
    while (!ref_req && w < 2 * T) begin @(negedge clk); w++; end
    chk("R4", w, T - 1);
    ref_ack = 1'b1; @(negedge clk); ref_ack = 1'b0;
    w = 0;
    while (!ref_req && w < 2 * T) begin @(negedge clk); w++; end
    chk("R4", w, T - 1);

    // R7 overdue once debt reaches 5
    w = 0;
    while (!overdue && w < 6 * T) begin @(negedge clk); w++; end
    chk("R7", w, 4 * T);

    // R5 five grants retire five owed refreshes
    drain(n);
    chk("R5", n, 5);
    chk("R7", int'(overdue), 0);

    // R3 acks with no request in run do not pre-pay
    ref_ack = 1'b1; repeat (4) @(negedge clk); ref_ack = 1'b0;
    w = 0;
    while (!ref_req && w < 2 * T) begin @(negedge clk); w++; end
    drain(n);
    chk("R3", n, 1);

    // R9 grant coinciding with a due tick
    w = 0;
    while (!(ms == 2 && md == 2 && mi == T - 1) && w < 4 * T) begin @(negedge clk); w++; end
    ref_ack = 1'b1; @(negedge clk); ref_ack = 1'b0;
    drain(n);
    chk("R9", n, 2);

    // R8 missed deadline forces a new wake burst
    exp = (T - mi) + DMAX * T;
    w = 0;
    while (init_done && w < 12 * T) begin @(negedge clk); w++; end
    chk("R8", w, exp);
    chk("R8", int'(ref_req), 1);
    chk("R8", int'(overdue), 0);
    ref_ack = 1'b1;
    for (int i = 1; i <= WK; i++) begin
      @(negedge clk);
      chk("R8", int'(init_done), int'(i == WK));
    end
    ref_ack = 1'b0;

    // mixed grant pattern, compared against the model every cycle (R5, R9)
    for (int i = 0; i < 4000; i++) begin
      ref_ack = ((i * 7) % 11 == 0) || ((i / 900) % 2 == 1 && i % 3 == 0);
      @(negedge clk);
    end
    ref_ack = 1'b0;
    @(negedge clk);
    finished = 1;
    summary();
  end
endmodule